// File: doc/BRIEF.md
# Ethernet receive address filter

This block judges an incoming Ethernet frame on its 48-bit destination address. The address arrives one bit per valid cycle, least significant bit first, after a start-of-frame strobe. The bits are compared on the fly against a programmed station address, and they are also checked for the all-ones broadcast pattern. One cycle after the 48th bit, the block gives a single-cycle verdict pulse together with an accept bit.

The station address and a three-bit mode word are held in four 16-bit registers. A small indexed write/read port gives access to them. That port works only while the controller's halt input is high. With halt low, writes have no effect and reads return zero.

The accept bit is set when any of these holds:
- promiscuous mode is on;
- the address matches the station and station matching is not disabled;
- the address is broadcast and broadcast reception is not disabled.

Top module: `rx_addr_filter`

## Requirements
- R1: Register index 0 holds station address bits 15:0, index 1 holds bits 31:16, and index 2 holds bits 47:32. Index 3 is the mode word: bit 15 is promiscuous, bit 14 is broadcast-disable and bit 13 is station-match-disable. Every other mode bit reads back as 0.
- R2: While `halt` is 0, register writes change nothing and reads return 0.
- R3: Writes to indices 4 to 7 are ignored, and reads of those indices return 0.
- R4: Reset clears the mode word to 0, so broadcast reception is enabled after reset. The verdict pulse is low after reset.
- R5: Incoming bit k (k = 0 first) is compared against station address bit k. `verdict_vld` is high for exactly the one cycle after the cycle that carried the 48th bit. Bits after the 48th do not produce another verdict.
- R6: A frame that matches the station address is accepted, unless station-match-disable is 1.
- R7: A frame sent to the all-ones address is accepted, unless broadcast-disable is 1.
- R8: When promiscuous is 1, every frame is accepted.
- R9: A frame that is neither a station match nor broadcast is rejected when promiscuous is 0.
- R10: `sof` restarts the comparison: the bit count and both running flags are re-armed. A frame cut short by a new `sof` produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| halt | input | 1 | Controller stopped; enables register access |
| reg_idx | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| sof | input | 1 | Start-of-frame strobe; carries no address bit |
| bit_vld | input | 1 | Address bit valid |
| bit_in | input | 1 | Serial destination address bit, LSB first |
| verdict_vld | output | 1 | Single-cycle verdict pulse |
| accept | output | 1 | Verdict; meaningful while verdict_vld is high |

## Verification
The embedded assertions check four things on every cycle:
- registers hold still and read as zero while `halt` is low;
- the verdict is a single-cycle pulse;
- promiscuous mode always yields acceptance;
- a verdict never follows a cycle without an address bit.

The directed scenarios cover the rest, because it depends on whole 48-bit sequences: bit-order matching against each register slice, the two disable bits, broadcast detection, re-arming by `sof` mid-frame, and silence after the 48th bit.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int REG_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sof,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             verdict_vld,
  output logic             accept
);
  localparam int ADDR_BITS = 3 * REG_W;
  localparam int CNT_W = $clog2(ADDR_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BITS);

  logic [ADDR_BITS-1:0] station;
  logic                 m_prom, m_nobc, m_nophys;
  logic [CNT_W-1:0]     cnt;
  logic                 match_q, ones_q;
  logic                 vld_q, acc_q;

  wire reg_access = halt && reg_wr;
  wire take_bit   = bit_vld && !sof && (cnt < DONE);
  wire match_nx   = match_q && (bit_in == station[cnt]);
  wire ones_nx    = ones_q && bit_in;

  always_ff @(posedge clk) begin
    if (reg_access) begin
      case (reg_idx)
        3'd0: station[REG_W-1:0]         <= reg_wdata;
        3'd1: station[2*REG_W-1:REG_W]   <= reg_wdata;
        3'd2: station[3*REG_W-1:2*REG_W] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prom   <= 1'b0;
      m_nobc   <= 1'b0;
      m_nophys <= 1'b0;
    end else if (reg_access && reg_idx == 3'd3) begin
      m_prom   <= reg_wdata[15];
      m_nobc   <= reg_wdata[14];
      m_nophys <= reg_wdata[13];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (halt) begin
      case (reg_idx)
        3'd0: reg_rdata = station[REG_W-1:0];
        3'd1: reg_rdata = station[2*REG_W-1:REG_W];
        3'd2: reg_rdata = station[3*REG_W-1:2*REG_W];
        3'd3: reg_rdata = {m_prom, m_nobc, m_nophys, {(REG_W-3){1'b0}}};
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= DONE;
      match_q <= 1'b0;
      ones_q  <= 1'b0;
      vld_q   <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      vld_q <= take_bit && (cnt == LAST);
      if (sof) begin
        cnt     <= '0;
        match_q <= 1'b1;
        ones_q  <= 1'b1;
      end else if (take_bit) begin
        cnt     <= cnt + 1'b1;
        match_q <= match_nx;
        ones_q  <= ones_nx;
        if (cnt == LAST)
          acc_q <= m_prom || (match_nx && !m_nophys) || (ones_nx && !m_nobc);
      end
    end
  end

  assign verdict_vld = vld_q;
  assign accept      = acc_q;

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> ($stable(station) && $stable({m_prom, m_nobc, m_nophys})));
  a_r2_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> reg_rdata == '0);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);
  a_r5_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(bit_vld && !sof));
  a_r8_prom_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(m_prom)) |-> accept);
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        halt = 0;
  logic [2:0]  reg_idx = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        sof = 0, bit_vld = 0, bit_in = 0;
  logic        verdict_vld, accept;
  int tests = 0, fails = 0;
  logic [47:0] STA = 48'h5A3C_91E7_02B4;

  rx_addr_filter uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [15:0] d);
    @(negedge clk); reg_idx = i; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [15:0] d);
    @(negedge clk); reg_idx = i; #1 d = reg_rdata;
  endtask

  task automatic frame(input logic [47:0] a, input int extra, output logic v, output logic acc, output logic late);
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0; bit_vld = 1;
    for (int k = 0; k < 48; k++) begin
      bit_in = a[k];
      if (k < 47) @(negedge clk);
    end
    @(posedge clk); #1 v = verdict_vld; acc = accept;
    late = 0;
    for (int k = 0; k < extra; k++) begin
      @(negedge clk); bit_in = k[0];
      @(posedge clk); #1 late |= verdict_vld;
    end
    @(negedge clk); bit_vld = 0;
    @(posedge clk); #1 late |= verdict_vld;
  endtask

  task automatic set_mode(input logic p, input logic b, input logic s);
    halt = 1; wr(3'd3, {p, b, s, 13'h1FFF});
  endtask

  task automatic t_reset();
    logic [15:0] d;
    halt = 1;
    rd(3'd3, d); chk("R4 mode cleared", d, 0);
    chk("R4 verdict low", verdict_vld, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(3'd0, STA[15:0]); wr(3'd1, STA[31:16]); wr(3'd2, STA[47:32]);
    rd(3'd0, d); chk("R1 idx0", d, STA[15:0]);
    rd(3'd1, d); chk("R1 idx1", d, STA[31:16]);
    rd(3'd2, d); chk("R1 idx2", d, STA[47:32]);
    set_mode(1, 0, 1);
    rd(3'd3, d); chk("R1 mode bits", d, 16'hA000);
    set_mode(0, 0, 0);
  endtask

  task automatic t_halt_gate();
    logic [15:0] d;
    halt = 0;
    wr(3'd0, 16'hFFFF); wr(3'd3, 16'hE000);
    rd(3'd0, d); chk("R2 read zero when running", d, 0);
    halt = 1;
    rd(3'd0, d); chk("R2 write ignored idx0", d, STA[15:0]);
    rd(3'd3, d); chk("R2 write ignored mode", d, 0);
  endtask

  task automatic t_unused();
    logic [15:0] d;
    for (int i = 4; i < 8; i++) wr(3'(i), 16'hFFFF);
    rd(3'd5, d); chk("R3 unused reads zero", d, 0);
    for (int i = 0; i < 3; i++) begin
      rd(3'(i), d); chk("R3 no alias", d, STA[16*i +: 16]);
    end
    rd(3'd3, d); chk("R3 mode untouched", d, 0);
  endtask

  task automatic t_filter();
    logic v, a, l;
    halt = 0;
    frame(STA, 5, v, a, l);
    chk("R5 verdict pulse", v, 1); chk("R6 station accept", a, 1); chk("R5 no late verdict", l, 0);
    frame({STA[47:1], ~STA[0]}, 0, v, a, l); chk("R9 bit0 mismatch reject", a, 0);
    frame({~STA[47], STA[46:0]}, 0, v, a, l); chk("R9 bit47 mismatch reject", a, 0);
    frame({STA[47:24], STA[0 +: 24]} ^ 48'h1, 0, v, a, l); chk("R9 other reject", a, 0);
    frame({48{1'b1}}, 0, v, a, l); chk("R7 broadcast accept", a, 1);
    set_mode(0, 1, 0); halt = 0;
    frame({48{1'b1}}, 0, v, a, l); chk("R7 broadcast disabled", a, 0);
    frame(STA, 0, v, a, l); chk("R6 station still ok", a, 1);
    set_mode(0, 0, 1); halt = 0;
    frame(STA, 0, v, a, l); chk("R6 station disabled", a, 0);
    frame({48{1'b1}}, 0, v, a, l); chk("R7 broadcast with phys off", a, 1);
    set_mode(1, 1, 1); halt = 0;
    frame(48'h0123_4567_89AB, 0, v, a, l); chk("R8 promiscuous accept", a, 1);
    set_mode(0, 0, 0); halt = 0;
  endtask

  task automatic t_restart();
    logic v, a, l;
    logic seen = 0;
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0; bit_vld = 1;
    for (int k = 0; k < 30; k++) begin
      bit_in = ~STA[k];
      @(posedge clk); #1 seen |= verdict_vld;
      @(negedge clk);
    end
    bit_vld = 0;
    chk("R10 truncated no verdict", seen, 0);
    frame(STA, 0, v, a, l);
    chk("R10 restart verdict", v, 1); chk("R10 restart accept", a, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_regs(); t_halt_gate(); t_unused(); t_filter(); t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule